// File: doc/BRIEF.md
# Decimating CRC-7 Serial Telemetry Framer

This block sits between a multi-channel sample converter and an on-off-keyed radio transmitter. Each incoming sample carries a channel tag and a 10-bit value. The block keeps one sample out of every four for each channel, counting each channel separately. For each kept sample it computes a 7-bit cyclic redundancy code and sends the tag, the sample and the code on a single serial line. The line uses start/stop character framing, like a common asynchronous serial port. The block runs on a clock at eight times the sample rate. The serial line stays high whenever no frame is in flight.

A kept sample is taken only when the transmitter is idle. A kept sample that arrives during a frame is dropped, and a sticky overflow flag records the drop. The transmitter is a four-state machine. TX_IDLE holds the line high. TX_START drives the low start bit. TX_DATA shifts out eight data bits. TX_STOP drives the high stop bit. The transitions are as follows. IDLE goes to START when a sample is loaded. START goes to DATA after one bit time. DATA goes to STOP after the eighth bit. STOP goes back to START when more characters remain. STOP goes to IDLE after the last character.

Top module: `telem_framer`

## Requirements
- R1: After reset the serial line is high, busy is low and overflow is low.
- R2: Each channel's first valid sample after reset is framed, and after that every fourth valid sample on that channel is framed. The other samples produce no frame: busy stays low and the line stays high.
- R3: A frame is three characters, 30 line bits in all. Each character is a start bit of 0, then eight data bits sent LSB first, then a stop bit of 1. Each bit lasts one clock.
- R4: The data of the three characters are bytes 0, 1 and 2 of a 24-bit word. Bits [2:0] of the word hold the channel, bits [12:3] the sample, bits [19:13] the CRC and bits [23:20] are zero.
- R5: The CRC is the remainder of the 13-bit message {channel, sample} × x^7, divided by x^7+x^3+1. The channel MSB is the highest-order message bit and the initial value is zero.
- R6: The start bit appears in the clock cycle right after the edge at which a kept sample is accepted. Busy is high from the start bit through the last stop bit and is low in the next cycle.
- R7: A kept sample that arrives while busy is high is not sent. The frame in flight is not changed, and overflow goes high and stays high until reset.
- R8: Every valid sample advances its channel's decimation count, including a kept sample that was dropped for overflow.
- R9: The line is high in every cycle where busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, eight times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 3 | Channel tag of the sample |
| smp_data | input | 10 | Sample value |
| ser_out | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in flight |
| overflow | output | 1 | Sticky flag: a kept sample was dropped |

## Verification
The bench builds the block with its default parameters: eight channels, a decimation factor of four, three 8-bit characters per frame and one clock per bit. With these values the bench can sweep every channel through a full decimation cycle and compare every line bit of every framed sample against a frame it builds itself, with the CRC worked out by polynomial long division. The sample values include all zeros and all ones. Because each bit lasts one clock, an overflow can be forced in the second bit of a frame. The bench then follows the dropped channel through its next decimation cycle.

// File: rtl/telem_pkg.sv
package telem_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/telem_decim.sv
module telem_decim #(
    parameter int N_CH  = 8,
    parameter int CH_W  = 3,
    parameter int DECIM = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid_i,
    input  logic [CH_W-1:0] in_ch_i,
    output logic            keep_o
);
    localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [CNT_W-1:0] phase [N_CH];
    logic [N_CH-1:0]  at_zero;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                phase[g] <= '0;
            end else if (in_valid_i && in_ch_i == CH_W'(g)) begin
                if (phase[g] == CNT_W'(DECIM - 1))
                    phase[g] <= '0;
                else
                    phase[g] <= phase[g] + 1'b1;
            end
        end
        assign at_zero[g] = (phase[g] == '0);
    end

    always_comb begin
        keep_o = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (in_valid_i && in_ch_i == CH_W'(i) && at_zero[i])
                keep_o = 1'b1;
        end
    end

    AST_DECIM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        keep_o |=> !(keep_o && in_ch_i == $past(in_ch_i))); // R2

endmodule

// File: rtl/telem_crc.sv
module telem_crc #(
    parameter int           MSG_W = 13,
    parameter int           CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic [MSG_W-1:0] msg_i,
    output logic [CRC_W-1:0] crc_o
);
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb  = msg_i[i] ^ acc[CRC_W-1];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb)
                acc = acc ^ POLY;
        end
        crc_o = acc;
    end

endmodule

// File: rtl/telem_frame_tx.sv
module telem_frame_tx
    import telem_pkg::*;
#(
    parameter int CHAR_W   = 8,
    parameter int N_CHARS  = 3,
    parameter int BIT_CLKS = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [N_CHARS*CHAR_W-1:0]   word_i,
    output logic                        ser_o,
    output logic                        busy_o
);
    localparam int WORD_W = N_CHARS * CHAR_W;
    localparam int TICK_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int BIDX_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam int CIDX_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;

    tx_state_e          state_q, state_d;
    logic [WORD_W-1:0]  shreg;
    logic [TICK_W-1:0]  tick;
    logic [BIDX_W-1:0]  bit_idx;
    logic [CIDX_W-1:0]  char_idx;
    logic               bit_done;
    logic               last_bit;
    logic               last_char;

    assign bit_done  = (tick == TICK_W'(BIT_CLKS - 1));
    assign last_bit  = (bit_idx == BIDX_W'(CHAR_W - 1));
    assign last_char = (char_idx == CIDX_W'(N_CHARS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load_i)                state_d = TX_START;
            TX_START: if (bit_done)              state_d = TX_DATA;
            TX_DATA:  if (bit_done && last_bit)  state_d = TX_STOP;
            TX_STOP:  if (bit_done)              state_d = last_char ? TX_IDLE : TX_START;
        endcase
    end

    // datapath: shift register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            tick     <= '0;
            bit_idx  <= '0;
            char_idx <= '0;
        end else if (state_q == TX_IDLE) begin
            tick     <= '0;
            bit_idx  <= '0;
            char_idx <= '0;
            if (load_i)
                shreg <= word_i;
        end else begin
            tick <= bit_done ? '0 : tick + 1'b1;
            if (bit_done && state_q == TX_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (bit_done && state_q == TX_STOP) begin
                bit_idx  <= '0;
                char_idx <= char_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ser_o  = 1'b1;
        busy_o = 1'b1;
        unique case (state_q)
            TX_IDLE:  busy_o = 1'b0;
            TX_START: ser_o  = 1'b0;
            TX_DATA:  ser_o  = shreg[0];
            TX_STOP:  ser_o  = 1'b1;
        endcase
    end

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> (busy_o && !ser_o)); // R6
    AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(ser_o)); // R3
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ser_o); // R9

endmodule

// File: rtl/telem_framer.sv
module telem_framer #(
    parameter int N_CH     = 8,
    parameter int CH_W     = 3,
    parameter int SAMP_W   = 10,
    parameter int CRC_W    = 7,
    parameter int DECIM    = 4,
    parameter int CHAR_W   = 8,
    parameter int BIT_CLKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic [SAMP_W-1:0] smp_data,
    output logic              ser_out,
    output logic              busy,
    output logic              overflow
);
    localparam int MSG_W   = CH_W + SAMP_W;
    localparam int BODY_W  = MSG_W + CRC_W;
    localparam int N_CHARS = (BODY_W + CHAR_W - 1) / CHAR_W;
    localparam int WORD_W  = N_CHARS * CHAR_W;
    localparam int PAD_W   = WORD_W - BODY_W;

    logic              keep;
    logic              accept;
    logic [CRC_W-1:0]  crc;
    logic [WORD_W-1:0] word;

    telem_decim #(.N_CH(N_CH), .CH_W(CH_W), .DECIM(DECIM)) i_decim (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (smp_valid),
        .in_ch_i    (smp_chan),
        .keep_o     (keep)
    );

    telem_crc #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(CRC_W'(9))) i_crc (
        .msg_i (MSG_W'({smp_chan, smp_data})),
        .crc_o (crc)
    );

    if (PAD_W > 0) begin : g_pad
        assign word = {{PAD_W{1'b0}}, crc, smp_data, smp_chan};
    end else begin : g_nopad
        assign word = {crc, smp_data, smp_chan};
    end

    assign accept = keep && !busy;

    telem_frame_tx #(.CHAR_W(CHAR_W), .N_CHARS(N_CHARS), .BIT_CLKS(BIT_CLKS)) i_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .word_i (word),
        .ser_o  (ser_out),
        .busy_o (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (keep && busy)
            overflow <= 1'b1;
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && busy) |=> overflow); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R7
    AST_DROP_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && busy && !$past(!busy)) |=> busy || $past(ser_out)); // R7

endmodule

// File: tb/test_telem_framer.sv
`timescale 1ns/1ps
module test_telem_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [2:0] smp_chan = '0;
    logic [9:0] smp_data = '0;
    logic       ser_out, busy, overflow;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    telem_framer i_telem_framer (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .ser_out(ser_out), .busy(busy), .overflow(overflow)
    );

    function automatic logic [6:0] ref_crc(input logic [2:0] ch, input logic [9:0] v);
        logic [19:0] r;
        r = {ch, v, 7'b0};
        for (int i = 19; i >= 7; i--)
            if (r[i]) r = r ^ (20'h89 << (i - 7));
        return r[6:0];
    endfunction

    function automatic logic [29:0] ref_line(input logic [2:0] ch, input logic [9:0] v);
        logic [23:0] w;
        logic [29:0] l;
        w = {4'b0, ref_crc(ch, v), v, ch};
        for (int c = 0; c < 3; c++) begin
            l[c*10] = 1'b0;
            for (int b = 0; b < 8; b++) l[c*10 + 1 + b] = w[c*8 + b];
            l[c*10 + 9] = 1'b1;
        end
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive a sample that must be framed, optionally inject a second sample in bit 1
    task automatic framed(input logic [2:0] ch, input logic [9:0] v,
                          input bit inj, input logic [2:0] ich, input logic [9:0] iv);
        logic [29:0] got;
        bit busy_ok;
        busy_ok = 1'b1;
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_data = v;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 0) begin
                if (inj) begin smp_chan = ich; smp_data = iv; end
                else smp_valid = 1'b0;
            end
            if (i == 1) smp_valid = 1'b0;
            got[i] = ser_out;
            if (!busy) busy_ok = 1'b0;
        end
        // R3 R4 R5: line bits match the reference frame
        check(got == ref_line(ch, v), "R3/R4/R5", "frame bits", {2'b0, got}, {2'b0, ref_line(ch, v)});
        check(busy_ok, "R6", "busy through frame", 32'(busy_ok), 1);
        @(negedge clk);
        check(!busy && ser_out, "R6/R9", "idle after frame", {busy, ser_out}, 32'b01);
    endtask

    // drive a sample that must not be framed
    task automatic dropped(input logic [2:0] ch, input logic [9:0] v, input string req);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
        check(!busy && ser_out, req, "no frame", {busy, ser_out}, 32'b01);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ser_out && !busy && !overflow, "R1", "reset state",
              {ser_out, busy, overflow}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_out && !busy && !overflow, "R1", "after reset release",
              {ser_out, busy, overflow}, 32'b100);

        // R2: sweep all channels through two decimation cycles
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 8; c++) begin
                logic [9:0] v;
                v = (c == 0) ? 10'h000 : (c == 7) ? 10'h3FF : 10'((c * 97 + r * 311 + 5) % 1024);
                framed(3'(c), v, 1'b0, 3'd0, 10'd0);
                for (int k = 1; k < 4; k++)
                    dropped(3'(c), 10'((c * 131 + k * 29) % 1024), "R2");
            end
        end
        check(!overflow, "R7", "no overflow in sweep", 32'(overflow), 0);

        // R7: kept ch1 sample during a ch0 frame is dropped
        framed(3'd0, 10'h2A5, 1'b1, 3'd1, 10'h155);
        check(overflow, "R7", "overflow set", 32'(overflow), 1);

        // R8: the dropped ch1 sample advanced its count
        for (int k = 0; k < 3; k++) dropped(3'd1, 10'(k + 1), "R8");
        framed(3'd1, 10'h0F0, 1'b0, 3'd0, 10'd0);
        check(overflow, "R7", "overflow sticky", 32'(overflow), 1);

        // R1: reset clears overflow
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(!overflow && ser_out && !busy, "R1", "reset clears flag",
              {ser_out, busy, overflow}, 32'b100);
        rst_n = 1'b1;
        framed(3'd5, 10'h001, 1'b0, 3'd0, 10'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule